// File: doc/BRIEF.md
# Interlaced TV Encoder Output Timer

This block drives an external TV encoder over an 8-bit parallel bus. On every enabled pixel clock it places one colour component byte (luma Y or chroma U/V) on the bus. It also generates three active-low strobes: a row strobe, a field strobe and a data-ready strobe. The timing is interlaced. An odd field and an even field alternate, and the receiver tells them apart by where the field-strobe falling edge lands relative to the row-strobe falling edge.

Bytes come from an upstream source through a ready/valid handshake. The block asks for a specific component on `req_comp`, following the repeating pattern U, Y, V, Y, which restarts with U on every row. During blanking it holds `src_ready` low. The pixel clock (nominally 27 MHz, within about ±10%) is qualified by `clk_en`; every counter and every output advances only on enabled edges.

The timing core is a two-state field machine. `FLD_ODD` moves to `FLD_EVEN` when the last line of the odd field ends, and `FLD_EVEN` moves back to `FLD_ODD` when the last line of the even field ends. Beside it runs a four-state component machine, `PH_U` → `PH_Y0` → `PH_V` → `PH_Y1` → `PH_U`. This machine advances once per accepted byte and is forced back to `PH_U` at each row start. A synchronous reset puts the block at the start of an odd field.

Top module: `ilace_tx_timer`

## Requirements
- R1: While `rst` is high, and afterwards until the first enabled edge, `row_sync_n`, `field_sync_n` and `data_rdy_n` are 1, `bus_data` is 0 and `req_comp` is U (code 0).
- R2: Count enabled edges since reset as k = 0, 1, 2, … and let h = k mod `LINE_CLKS` be the position in the line. After the enabled edge of index k, `row_sync_n` is 0 exactly when h = 0. It is therefore low for one enabled cycle in every `LINE_CLKS`.
- R3: On the first line of an odd field, `field_sync_n` is 0 for positions h in 0 .. `FS_LEN`-1. Its falling edge therefore coincides with the row-strobe falling edge.
- R4: On the first line of an even field, `field_sync_n` is 0 for positions h in `LINE_CLKS`/2 .. `LINE_CLKS`/2+`FS_LEN`-1. Its falling edge therefore never coincides with a row-strobe falling edge.
- R5: A frame is `ODD_LINES` odd-field lines followed by `EVEN_LINES` even-field lines, and frames repeat. `field_sync_n` is 1 on every other line.
- R6: `src_ready` is 1 exactly when `clk_en` is 1 and the current position h lies in 1 .. `ACTIVE_BYTES`. It is never 1 at the row-strobe position or in blanking.
- R7: After an enabled edge where `src_valid` and `src_ready` were both 1, `data_rdy_n` is 0 and `bus_data` holds the accepted byte. After any other enabled edge, `data_rdy_n` is 1 and `bus_data` is 0. A low `data_rdy_n` implies a high `row_sync_n`.
- R8: `req_comp` (U=0, Y=1, V=2) follows U, Y, V, Y, U, … It advances only on an accepted byte, and it returns to U at each row start.
- R9: While `clk_en` is 0, no output and no counter changes, and no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Pixel clock enable |
| src_data | input | 8 | Component byte from upstream |
| src_valid | input | 1 | Upstream byte available |
| src_ready | output | 1 | Block takes the byte on this edge |
| req_comp | output | 2 | Component wanted next: 0=U, 1=Y, 2=V |
| bus_data | output | 8 | Parallel byte to the encoder |
| row_sync_n | output | 1 | Row strobe, active low |
| field_sync_n | output | 1 | Field strobe, active low |
| data_rdy_n | output | 1 | Byte-valid strobe, active low |

## Verification
The bench randomly stalls both the source and the clock enable across several whole frames. A design that advanced its position counter, its component pattern or its strobes while `clk_en` was low would drift out of step with the bench's line and field arithmetic. The field boundaries are checked on every line. Placing the even-field strobe on the row edge, or getting a field one line too long or too short, would break the expected coincidence pattern. Directed runs with the source always valid and never valid expose a component pattern that does not restart at U on each row, and a data strobe or non-zero byte left standing in an idle slot. A reset applied mid-frame checks that output restarts at the head of an odd field.

// File: rtl/ilace_tx_pkg.sv
package ilace_tx_pkg;
    typedef enum logic [1:0] {
        COMP_U = 2'd0,
        COMP_Y = 2'd1,
        COMP_V = 2'd2
    } comp_t;

    typedef enum logic {
        FLD_ODD  = 1'b0,
        FLD_EVEN = 1'b1
    } field_t;

    typedef enum logic [1:0] {
        PH_U  = 2'd0,
        PH_Y0 = 2'd1,
        PH_V  = 2'd2,
        PH_Y1 = 2'd3
    } phase_t;
endpackage

// File: rtl/ilace_line_timer.sv
module ilace_line_timer #(
    parameter int LINE_CLKS = 32,
    localparam int HW = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    output logic [HW-1:0] hpos,
    output logic          line_last
);
    logic [HW-1:0] hpos_q;

    assign hpos      = hpos_q;
    assign line_last = (hpos_q == HW'(LINE_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos_q <= '0;
        end else if (clk_en) begin
            if (line_last) hpos_q <= '0;
            else           hpos_q <= hpos_q + 1'b1;
        end
    end

    // R2: the line position wraps to zero after the last position
    a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
        (clk_en && line_last) |=> (hpos_q == '0));

    // R9: the position holds while the enable is low
    a_r9_hpos_hold: assert property (@(posedge clk) disable iff (rst)
        (!clk_en) |=> $stable(hpos_q));
endmodule

// File: rtl/ilace_field_fsm.sv
module ilace_field_fsm
    import ilace_tx_pkg::*;
#(
    parameter int ODD_LINES  = 5,
    parameter int EVEN_LINES = 4,
    localparam int MAXL = (ODD_LINES > EVEN_LINES) ? ODD_LINES : EVEN_LINES,
    localparam int VW   = (MAXL > 1) ? $clog2(MAXL) : 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output field_t field,
    output logic   first_line
);
    field_t        state_q, state_d;
    logic [VW-1:0] vpos_q, vpos_d;
    logic          odd_done, even_done;

    assign odd_done  = (vpos_q == VW'(ODD_LINES - 1));
    assign even_done = (vpos_q == VW'(EVEN_LINES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLD_ODD;
            vpos_q  <= '0;
        end else begin
            state_q <= state_d;
            vpos_q  <= vpos_d;
        end
    end

    always_comb begin
        state_d = state_q;
        vpos_d  = vpos_q;
        if (step) begin
            unique case (state_q)
                FLD_ODD: begin
                    if (odd_done) begin
                        state_d = FLD_EVEN;
                        vpos_d  = '0;
                    end else begin
                        vpos_d = vpos_q + 1'b1;
                    end
                end
                FLD_EVEN: begin
                    if (even_done) begin
                        state_d = FLD_ODD;
                        vpos_d  = '0;
                    end else begin
                        vpos_d = vpos_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign field      = state_q;
    assign first_line = (vpos_q == '0);

    // R5: the odd field hands over to the even field after its last line
    a_r5_odd_to_even: assert property (@(posedge clk) disable iff (rst)
        (step && state_q == FLD_ODD && odd_done) |=> (state_q == FLD_EVEN && vpos_q == '0));

    // R5: the even field hands back to the next odd field
    a_r5_even_to_odd: assert property (@(posedge clk) disable iff (rst)
        (step && state_q == FLD_EVEN && even_done) |=> (state_q == FLD_ODD && vpos_q == '0));
endmodule

// File: rtl/ilace_byte_lane.sv
module ilace_byte_lane
    import ilace_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          row_start,
    input  logic          accept,
    input  logic [DW-1:0] src_data,
    output comp_t         comp,
    output logic [DW-1:0] bus_data,
    output logic          data_rdy_n
);
    phase_t phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_U;
        else     phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        if (clk_en && row_start) begin
            phase_d = PH_U;
        end else if (accept) begin
            unique case (phase_q)
                PH_U:  phase_d = PH_Y0;
                PH_Y0: phase_d = PH_V;
                PH_V:  phase_d = PH_Y1;
                PH_Y1: phase_d = PH_U;
            endcase
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_U:         comp = COMP_U;
            PH_V:         comp = COMP_V;
            PH_Y0, PH_Y1: comp = COMP_Y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_data   <= '0;
            data_rdy_n <= 1'b1;
        end else if (clk_en) begin
            bus_data   <= accept ? src_data : '0;
            data_rdy_n <= !accept;
        end
    end

    // R8: the pattern closes on U after the second luma byte
    a_r8_wrap_to_u: assert property (@(posedge clk) disable iff (rst)
        (accept && phase_q == PH_Y1) |=> (phase_q == PH_U));

    // R7: an accepted byte raises the strobe on the next cycle
    a_r7_strobe_on_take: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!data_rdy_n && bus_data == $past(src_data)));
endmodule

// File: rtl/ilace_tx_timer.sv
module ilace_tx_timer
    import ilace_tx_pkg::*;
#(
    parameter int LINE_CLKS    = 32,
    parameter int ACTIVE_BYTES = 16,
    parameter int ODD_LINES    = 5,
    parameter int EVEN_LINES   = 4,
    parameter int FS_LEN       = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic [7:0] src_data,
    input  logic       src_valid,
    output logic       src_ready,
    output logic [1:0] req_comp,
    output logic [7:0] bus_data,
    output logic       row_sync_n,
    output logic       field_sync_n,
    output logic       data_rdy_n
);
    localparam int HW   = $clog2(LINE_CLKS);
    localparam int HALF = LINE_CLKS / 2;

    logic [HW-1:0] hpos;
    logic          line_last, first_line, active, accept, fs_zone, row_start;
    field_t        field;
    comp_t         comp;

    ilace_line_timer #(.LINE_CLKS(LINE_CLKS)) u_line (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .hpos      (hpos),
        .line_last (line_last)
    );

    ilace_field_fsm #(.ODD_LINES(ODD_LINES), .EVEN_LINES(EVEN_LINES)) u_field (
        .clk        (clk),
        .rst        (rst),
        .step       (clk_en && line_last),
        .field      (field),
        .first_line (first_line)
    );

    assign row_start = (hpos == '0);
    assign active    = (int'(hpos) >= 1) && (int'(hpos) <= ACTIVE_BYTES);
    assign src_ready = clk_en && active;
    assign accept    = src_ready && src_valid;

    always_comb begin
        fs_zone = 1'b0;
        if (first_line) begin
            unique case (field)
                FLD_ODD:  fs_zone = (int'(hpos) < FS_LEN);
                FLD_EVEN: fs_zone = (int'(hpos) >= HALF) && (int'(hpos) < HALF + FS_LEN);
            endcase
        end
    end

    ilace_byte_lane #(.DW(8)) u_lane (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .row_start  (row_start),
        .accept     (accept),
        .src_data   (src_data),
        .comp       (comp),
        .bus_data   (bus_data),
        .data_rdy_n (data_rdy_n)
    );

    assign req_comp = comp;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_sync_n   <= 1'b1;
            field_sync_n <= 1'b1;
        end else if (clk_en) begin
            row_sync_n   <= !row_start;
            field_sync_n <= !fs_zone;
        end
    end

    // R7: data never shares a cycle with the row strobe
    a_r7_no_data_in_sync: assert property (@(posedge clk) disable iff (rst)
        !data_rdy_n |-> row_sync_n);

    // R6: the source is never asked for a byte on the row position
    a_r6_ready_off_row: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> !row_start);

    // R9: outputs stay put across a disabled edge
    a_r9_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(row_sync_n) && $stable(field_sync_n) && $stable(data_rdy_n) && $stable(bus_data)));

    // R2: the row strobe lasts a single enabled cycle
    a_r2_row_short: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !row_sync_n) |=> row_sync_n);
endmodule

// File: tb/sim_ilace_tx_timer.sv
module sim_ilace_tx_timer;
    localparam int L    = 32;
    localparam int ACT  = 16;
    localparam int NO   = 5;
    localparam int NE   = 4;
    localparam int FS   = 3;
    localparam int HALF = L / 2;
    localparam int FRAME = (NO + NE) * L;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_valid = 1'b0;
    logic       src_ready;
    logic [1:0] req_comp;
    logic [7:0] bus_data;
    logic       row_sync_n, field_sync_n, data_rdy_n;

    int n_checks = 0;
    int n_fail   = 0;
    int k        = 0;
    int comp_idx = 0;
    logic       e_row = 1'b1, e_fs = 1'b1, e_rdy = 1'b1;
    logic [7:0] e_data = 8'h00;
    string      fs_tag = "R1";
    bit         last_dis = 1'b0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    ilace_tx_timer #(.LINE_CLKS(L), .ACTIVE_BYTES(ACT), .ODD_LINES(NO),
                     .EVEN_LINES(NE), .FS_LEN(FS)) u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .src_data(src_data),
        .src_valid(src_valid), .src_ready(src_ready), .req_comp(req_comp),
        .bus_data(bus_data), .row_sync_n(row_sync_n),
        .field_sync_n(field_sync_n), .data_rdy_n(data_rdy_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d (k=%0d)", req, what, act, exp, k);
        end
    endtask

    function automatic int comp_of(input int idx);
        case (idx % 4)
            0:       return 0;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

    function automatic bit fs_low(input int kk, output string tag);
        int q, h, line;
        bit odd;
        q = kk % FRAME;
        h = q % L;
        odd = (q < NO * L);
        line = odd ? q / L : (q - NO * L) / L;
        if (line != 0) begin
            tag = "R5";
            return 1'b0;
        end
        tag = odd ? "R3" : "R4";
        return odd ? (h < FS) : (h >= HALF && h < HALF + FS);
    endfunction

    task automatic check_outputs();
        string t9;
        t9 = last_dis ? "R9" : "R2";
        chk(t9, "row_sync_n", int'(row_sync_n), int'(e_row));
        chk(last_dis ? "R9" : fs_tag, "field_sync_n", int'(field_sync_n), int'(e_fs));
        chk(last_dis ? "R9" : "R7", "data_rdy_n", int'(data_rdy_n), int'(e_rdy));
        chk(last_dis ? "R9" : "R7", "bus_data", int'(bus_data), int'(e_data));
    endtask

    task automatic step(input int p_valid, input int p_en);
        int h;
        bit acc;
        string tg;
        @(negedge clk);
        check_outputs();
        clk_en    = (($urandom % 100) < p_en);
        src_valid = (($urandom % 100) < p_valid);
        src_data  = 8'($urandom);
        #1;
        h = k % L;
        chk("R6", "src_ready", int'(src_ready), int'(clk_en && h >= 1 && h <= ACT));
        chk("R8", "req_comp", int'(req_comp), comp_of(comp_idx));
        last_dis = !clk_en;
        if (clk_en) begin
            acc    = (h >= 1 && h <= ACT) && src_valid;
            e_row  = (h != 0);
            e_fs   = !fs_low(k, tg);
            fs_tag = tg;
            e_rdy  = !acc;
            e_data = acc ? src_data : 8'h00;
            if (h == 0)   comp_idx = 0;
            else if (acc) comp_idx++;
            k++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clk_en = ($urandom % 2) == 1;
        src_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clk_en = 1'b0;
        k = 0; comp_idx = 0;
        e_row = 1'b1; e_fs = 1'b1; e_rdy = 1'b1; e_data = 8'h00;
        fs_tag = "R1"; last_dis = 1'b0;
        #1;
        chk("R1", "row_sync_n", int'(row_sync_n), 1);
        chk("R1", "field_sync_n", int'(field_sync_n), 1);
        chk("R1", "data_rdy_n", int'(data_rdy_n), 1);
        chk("R1", "bus_data", int'(bus_data), 0);
        chk("R1", "req_comp", int'(req_comp), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // directed: full-rate source, always enabled, two frames
        repeat (2 * FRAME) step(100, 100);
        // directed: silent source, no bytes may appear
        repeat (L * 2) step(0, 100);
        // random stalls on both sides over several frames
        repeat (4 * FRAME) step(70, 80);
        // reset in mid frame, then restart from an odd field
        repeat (37) step(90, 90);
        do_reset();
        repeat (FRAME + L) step(85, 95);
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule